// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block keeps the programmable byte count for the DMA engine of a bus controller. The host writes the count one byte at a time into a pair of shadow registers. The shadow registers are copied into a live count only when the host issues a command that has the DMA flag set. The live count is visible to the host at all times.

When a DMA transfer-information command starts, the block works out how many bytes the transfer will move. A programmed count of zero stands for the full 65536-byte range. That length is then clipped: in command mode it is limited to 32 bytes, and otherwise it is limited to the magnitude of the signed pending device count.

During the transfer, the memory side acknowledges chunks on a valid/ready channel. `ack_ready` is high only while a transfer is running and bytes remain. A chunk is accepted in a cycle where both `ack_valid` and `ack_ready` are high. A producer that sees `ack_ready` low must hold its chunk.

Each accepted chunk reduces the remaining count and updates the pending device count. When nothing remains, the block raises terminal count, clears the live count and pulses a completion strobe that the controller turns into an interrupt.

Top module: `xfer_len_counter`

## Requirements
- R1: After reset the live count, the shadow bytes, the remaining count, `term_count`, `xfer_busy`, `xfer_done` and `ack_ready` are all zero.
- R2: A host write goes to the low byte when `host_wr_sel` is 0 and to the middle byte when it is 1. It changes only the shadow copy. `live_count` keeps its value through the write and through any command issued with `cmd_dma` low.
- R3: A `cmd_start` with `cmd_dma` high copies the shadow bytes into `live_count`, as {middle, low}. This happens whether or not `cmd_xfer` is set.
- R4: A host write to either count byte clears `term_count` on the next cycle.
- R5: A programmed count of zero is treated as 65536 bytes.
- R6: Outside command mode, the effective length is the smaller of the count and the magnitude of the signed `pend_in`.
- R7: In command mode (`cmd_mode` high), the effective length is the smaller of the count and 32, and `pend_in` is ignored.
- R8: `cmd_start` with both `cmd_dma` and `cmd_xfer` high does the following on the next cycle:
  - sets `xfer_busy`;
  - loads `eff_len` and `remaining` with the effective length;
  - clears `term_count`.
  
  `ack_ready` is high only while the block is busy and `remaining` is non-zero. Each accepted chunk lowers `remaining`, and `remaining` saturates at zero.
- R9: When the pending count at start is negative (toward the device), each accepted chunk is added to `pend_out`. When it is zero or positive (from the device), each chunk is subtracted. A command-mode transfer leaves `pend_out` unchanged.
- R10: One cycle after `remaining` reaches zero while busy, the block does all of the following together:
  - pulses `xfer_done`;
  - sets `term_count`;
  - zeroes `live_count`;
  - drops `xfer_busy`.
- R11: `xfer_done` is high for exactly one cycle per completion.
- R12: A transfer whose effective length is zero starts with `ack_ready` low. It completes one cycle after the start without any chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_valid | input | 1 | Host write strobe for a count byte |
| host_wr_sel | input | SEL_W | Byte select: 0 low, 1 middle |
| host_wr_data | input | 8 | Byte written by the host |
| cmd_start | input | 1 | Command issue strobe |
| cmd_dma | input | 1 | DMA flag of the issued command |
| cmd_xfer | input | 1 | Issued command is transfer-information |
| cmd_mode | input | 1 | Controller is collecting command bytes |
| pend_in | input | PEND_W | Signed pending device byte count |
| ack_valid | input | 1 | Chunk acknowledgement valid |
| ack_ready | output | 1 | Block can accept a chunk |
| ack_len | input | CNT_W+1 | Bytes in the acknowledged chunk |
| live_count | output | CNT_W | Live count readable by the host |
| eff_len | output | CNT_W+1 | Effective length of the last transfer |
| remaining | output | CNT_W+1 | Bytes still to move |
| pend_out | output | PEND_W | Tracked signed pending count |
| xfer_busy | output | 1 | Transfer in progress |
| term_count | output | 1 | Terminal-count status |
| xfer_done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its defaults:
- a 16-bit count, so the zero-means-65536 case and full-width counts are reachable;
- an 18-bit signed pending count, which can exceed 65536 and so lets the count itself become the limiting term;
- a 32-byte command-mode cap, which is easy to reach with small counts, so both sides of each clip are covered.

Directed runs cover both transfer directions, command mode, saturating acknowledgement, a zero-length start, and terminal-count clearing by a write and by a start.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/xlc_count_regs.sv
module xlc_count_regs
  import xlc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [SEL_W-1:0] wr_sel,
  input  byte_t            wr_data,
  input  logic             reload,
  input  logic             zero_live,
  output logic [CNT_W-1:0] wr_count,
  output logic [CNT_W-1:0] live_count
);
  localparam int NB = CNT_W / BYTE_W;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    byte_t shadow_q;
    byte_t live_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q <= '0;
        live_q   <= '0;
      end else begin
        if (wr_valid && wr_sel == SEL_W'(b))
          shadow_q <= wr_data;
        if (reload)
          live_q <= shadow_q;
        else if (zero_live)
          live_q <= '0;
      end
    end

    assign wr_count[b*BYTE_W +: BYTE_W]   = shadow_q;
    assign live_count[b*BYTE_W +: BYTE_W] = live_q;
  end
endmodule

// File: rtl/xlc_len_calc.sv
module xlc_len_calc #(
  parameter int CNT_W   = 16,
  parameter int PEND_W  = 18,
  parameter int CMD_CAP = 32
) (
  input  logic [CNT_W-1:0]         count,
  input  logic                     cmd_mode,
  input  logic signed [PEND_W-1:0] pend,
  output logic [CNT_W:0]           eff
);
  localparam int LEN_W = CNT_W + 1;
  localparam int CW    = (LEN_W > PEND_W) ? LEN_W : PEND_W;

  logic [PEND_W-1:0] mag;
  logic [CW-1:0]     full;
  logic [CW-1:0]     cap;
  logic [CW-1:0]     pick;

  always_comb begin
    mag  = pend[PEND_W-1] ? (~pend + 1'b1) : pend;
    full = (count == '0) ? (CW'(1) << CNT_W) : CW'(count);
    cap  = cmd_mode ? CW'(CMD_CAP) : CW'(mag);
    pick = (full < cap) ? full : cap;
    eff  = LEN_W'(pick);
  end
endmodule

// File: rtl/xlc_xfer_track.sv
module xlc_xfer_track #(
  parameter int CNT_W  = 16,
  parameter int PEND_W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     mode,
  input  logic [CNT_W:0]           eff_in,
  input  logic signed [PEND_W-1:0] pend_in,
  input  logic                     host_wr,
  input  logic                     ack_valid,
  input  logic [CNT_W:0]           ack_len,
  output logic                     ack_ready,
  output logic [CNT_W:0]           eff_len,
  output logic [CNT_W:0]           remaining,
  output logic signed [PEND_W-1:0] pend_out,
  output logic                     busy,
  output logic                     tc,
  output logic                     done,
  output logic                     finish
);
  logic [CNT_W:0]           rem_q, eff_q;
  logic signed [PEND_W-1:0] pend_q;
  logic                     busy_q, tc_q, done_q, to_dev_q, cmd_q;
  logic                     accept;
  logic signed [PEND_W-1:0] ack_ext;

  assign finish    = busy_q && (rem_q == '0);
  assign ack_ready = busy_q && (rem_q != '0);
  assign accept    = ack_valid && ack_ready;
  assign ack_ext   = PEND_W'(ack_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q    <= '0;
      eff_q    <= '0;
      pend_q   <= '0;
      busy_q   <= 1'b0;
      tc_q     <= 1'b0;
      done_q   <= 1'b0;
      to_dev_q <= 1'b0;
      cmd_q    <= 1'b0;
    end else begin
      done_q <= finish;
      if (host_wr)
        tc_q <= 1'b0;
      if (start) begin
        busy_q   <= 1'b1;
        rem_q    <= eff_in;
        eff_q    <= eff_in;
        pend_q   <= pend_in;
        to_dev_q <= pend_in[PEND_W-1];
        cmd_q    <= mode;
        tc_q     <= 1'b0;
      end else if (finish) begin
        busy_q <= 1'b0;
        tc_q   <= 1'b1;
      end else if (accept) begin
        rem_q <= (ack_len >= rem_q) ? '0 : rem_q - ack_len;
        if (!cmd_q)
          pend_q <= to_dev_q ? pend_q + ack_ext : pend_q - ack_ext;
      end
    end
  end

  assign eff_len   = eff_q;
  assign remaining = rem_q;
  assign pend_out  = pend_q;
  assign busy      = busy_q;
  assign tc        = tc_q;
  assign done      = done_q;
endmodule

// File: rtl/xfer_len_counter.sv
module xfer_len_counter
  import xlc_pkg::*;
#(
  parameter int  CNT_W   = 16,
  parameter int  PEND_W  = 18,
  parameter int  CMD_CAP = 32,
  localparam int NB      = CNT_W / BYTE_W,
  localparam int SEL_W   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr_valid,
  input  logic [SEL_W-1:0]         host_wr_sel,
  input  logic [7:0]               host_wr_data,
  input  logic                     cmd_start,
  input  logic                     cmd_dma,
  input  logic                     cmd_xfer,
  input  logic                     cmd_mode,
  input  logic signed [PEND_W-1:0] pend_in,
  input  logic                     ack_valid,
  output logic                     ack_ready,
  input  logic [CNT_W:0]           ack_len,
  output logic [CNT_W-1:0]         live_count,
  output logic [CNT_W:0]           eff_len,
  output logic [CNT_W:0]           remaining,
  output logic signed [PEND_W-1:0] pend_out,
  output logic                     xfer_busy,
  output logic                     term_count,
  output logic                     xfer_done
);
  logic             reload, start, finish;
  logic [CNT_W-1:0] wr_count;
  logic [CNT_W:0]   eff_next;

  assign reload = cmd_start && cmd_dma;
  assign start  = reload && cmd_xfer;

  xlc_count_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (host_wr_valid),
    .wr_sel     (host_wr_sel),
    .wr_data    (host_wr_data),
    .reload     (reload),
    .zero_live  (finish),
    .wr_count   (wr_count),
    .live_count (live_count)
  );

  xlc_len_calc #(.CNT_W(CNT_W), .PEND_W(PEND_W), .CMD_CAP(CMD_CAP)) u_len (
    .count    (wr_count),
    .cmd_mode (cmd_mode),
    .pend     (pend_in),
    .eff      (eff_next)
  );

  xlc_xfer_track #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (cmd_mode),
    .eff_in    (eff_next),
    .pend_in   (pend_in),
    .host_wr   (host_wr_valid),
    .ack_valid (ack_valid),
    .ack_len   (ack_len),
    .ack_ready (ack_ready),
    .eff_len   (eff_len),
    .remaining (remaining),
    .pend_out  (pend_out),
    .busy      (xfer_busy),
    .tc        (term_count),
    .done      (xfer_done),
    .finish    (finish)
  );
endmodule

// File: rtl/xlc_checker.sv
module xlc_checker #(
  parameter int CNT_W   = 16,
  parameter int CMD_CAP = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr_valid,
  input logic             cmd_start,
  input logic             cmd_dma,
  input logic             cmd_xfer,
  input logic             cmd_mode,
  input logic             ack_ready,
  input logic [CNT_W-1:0] live_count,
  input logic [CNT_W:0]   eff_len,
  input logic [CNT_W:0]   remaining,
  input logic             xfer_busy,
  input logic             term_count,
  input logic             xfer_done
);
  logic go;
  logic ending;
  assign go     = cmd_start && cmd_dma && cmd_xfer;
  assign ending = xfer_busy && remaining == '0;

  assert_live_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_start && cmd_dma) && !ending) |=> $stable(live_count));

  assert_wr_clears_tc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_valid && !ending) |=> !term_count);

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eff_len <= (CNT_W+1)'(1) << CNT_W);

  assert_cmd_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_mode) |=> eff_len <= (CNT_W+1)'(CMD_CAP));

  assert_start_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (xfer_busy && !term_count));

  assert_rem_nonincr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !go) |=> remaining <= $past(remaining));

  assert_idle_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> !ack_ready);

  assert_done_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_busy) |-> (term_count && live_count == '0));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_busy) |=> !xfer_done);
endmodule

bind xfer_len_counter xlc_checker #(.CNT_W(CNT_W), .CMD_CAP(CMD_CAP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_wr_valid (host_wr_valid),
  .cmd_start     (cmd_start),
  .cmd_dma       (cmd_dma),
  .cmd_xfer      (cmd_xfer),
  .cmd_mode      (cmd_mode),
  .ack_ready     (ack_ready),
  .live_count    (live_count),
  .eff_len       (eff_len),
  .remaining     (remaining),
  .xfer_busy     (xfer_busy),
  .term_count    (term_count),
  .xfer_done     (xfer_done)
);

// File: tb/xfer_len_counter_bench.sv
module xfer_len_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV         = 9;

  localparam logic [15:0] V_CNT  [NV] = '{16'h0010, 16'h0100, 16'h0100, 16'h0000,
                                         16'h0000, 16'h0040, 16'h0010, 16'h0000, 16'h1234};
  localparam bit          V_MODE [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0};
  localparam int          V_PEND [NV] = '{100, 40, -50, 70000, -1000, 5, 0, 0, 4660};
  localparam int          V_EFF  [NV] = '{16, 40, 50, 65536, 1000, 32, 16, 32, 4660};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr_valid = 1'b0;
  logic [0:0] host_wr_sel = '0;
  logic [7:0] host_wr_data = '0;
  logic cmd_start = 1'b0, cmd_dma = 1'b0, cmd_xfer = 1'b0, cmd_mode = 1'b0;
  logic signed [17:0] pend_in = '0;
  logic ack_valid = 1'b0;
  logic ack_ready;
  logic [16:0] ack_len = '0;
  logic [15:0] live_count;
  logic [16:0] eff_len, remaining;
  logic signed [17:0] pend_out;
  logic xfer_busy, term_count, xfer_done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_len_counter u_xfer_len_counter (
    .clk(clk), .rst_n(rst_n),
    .host_wr_valid(host_wr_valid), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
    .cmd_start(cmd_start), .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer), .cmd_mode(cmd_mode),
    .pend_in(pend_in), .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_len(ack_len),
    .live_count(live_count), .eff_len(eff_len), .remaining(remaining), .pend_out(pend_out),
    .xfer_busy(xfer_busy), .term_count(term_count), .xfer_done(xfer_done)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hwrite(bit sel, logic [7:0] data);
    host_wr_valid = 1'b1; host_wr_sel = sel; host_wr_data = data;
    tick();
    host_wr_valid = 1'b0;
  endtask

  task automatic issue(bit dma, bit xfer, bit mode, int pend);
    cmd_start = 1'b1; cmd_dma = dma; cmd_xfer = xfer; cmd_mode = mode;
    pend_in = 18'(pend);
    tick();
    cmd_start = 1'b0; cmd_dma = 1'b0; cmd_xfer = 1'b0;
  endtask

  task automatic ack(int len);
    ack_valid = 1'b1; ack_len = 17'(len);
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 live", int'(live_count), 0);
    check("R1 busy", int'(xfer_busy), 0);
    check("R1 tc", int'(term_count), 0);
    check("R1 done", int'(xfer_done), 0);
    check("R1 ready", int'(ack_ready), 0);
    check("R1 rem", int'(remaining), 0);

    // R2 shadow write does not reach live count without a DMA command
    hwrite(1'b0, 8'h05);
    check("R2 live after write", int'(live_count), 0);
    issue(1'b0, 1'b1, 1'b0, 10);
    check("R2 live after non-DMA cmd", int'(live_count), 0);
    check("R2 no start", int'(xfer_busy), 0);
    // R3 DMA command without transfer still reloads
    issue(1'b1, 1'b0, 1'b0, 10);
    check("R3 live reload", int'(live_count), 5);
    check("R3 not busy", int'(xfer_busy), 0);

    // table of length vectors: R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      hwrite(1'b0, V_CNT[i][7:0]);
      hwrite(1'b1, V_CNT[i][15:8]);
      issue(1'b1, 1'b1, V_MODE[i], V_PEND[i]);
      check($sformatf("R3 vec%0d live", i), int'(live_count), int'(V_CNT[i]));
      check($sformatf("R5/R6/R7 vec%0d eff", i), int'(eff_len), V_EFF[i]);
      check($sformatf("R8 vec%0d rem", i), int'(remaining), V_EFF[i]);
    end

    // transfer from the device: R8 R9 R10 R11
    hwrite(1'b0, 8'd10);
    hwrite(1'b1, 8'd0);
    issue(1'b1, 1'b1, 1'b0, 6);
    check("R6 eff from dev", int'(eff_len), 6);
    check("R8 ready", int'(ack_ready), 1);
    ack(2);
    check("R8 rem after ack", int'(remaining), 4);
    check("R9 pend from dev", int'(pend_out), 4);
    ack(4);
    check("R8 rem zero", int'(remaining), 0);
    check("R9 pend zero", int'(pend_out), 0);
    check("R10 done not yet", int'(xfer_done), 0);
    tick();
    check("R10 done", int'(xfer_done), 1);
    check("R10 tc", int'(term_count), 1);
    check("R10 live zero", int'(live_count), 0);
    check("R10 idle", int'(xfer_busy), 0);
    tick();
    check("R11 done one cycle", int'(xfer_done), 0);

    // R4 write clears terminal count
    hwrite(1'b0, 8'd8);
    check("R4 tc cleared", int'(term_count), 0);

    // toward the device: R9
    issue(1'b1, 1'b1, 1'b0, -20);
    check("R6 eff to dev", int'(eff_len), 8);
    ack(8);
    check("R9 pend to dev", int'(pend_out), -12);
    tick();
    check("R10 tc to dev", int'(term_count), 1);

    // R8 start clears terminal count; R7 R9 command mode
    issue(1'b1, 1'b1, 1'b1, 7);
    check("R8 start clears tc", int'(term_count), 0);
    check("R7 eff small count", int'(eff_len), 8);
    ack(8);
    check("R9 cmd pend held", int'(pend_out), 7);
    tick();
    check("R10 cmd done", int'(xfer_done), 1);
    hwrite(1'b0, 8'd40);
    issue(1'b1, 1'b1, 1'b1, 7);
    check("R7 eff capped", int'(eff_len), 32);
    // R8 saturation
    ack(50);
    check("R8 saturate", int'(remaining), 0);
    tick();
    check("R10 sat done", int'(xfer_done), 1);

    // R12 zero effective length
    hwrite(1'b0, 8'd5);
    issue(1'b1, 1'b1, 1'b0, 0);
    check("R12 eff zero", int'(eff_len), 0);
    check("R12 not ready", int'(ack_ready), 0);
    check("R12 busy", int'(xfer_busy), 1);
    tick();
    check("R12 done", int'(xfer_done), 1);
    check("R12 tc", int'(term_count), 1);
    check("R8 idle not ready", int'(ack_ready), 0);

    report();
    $finish;
  end
endmodule